// File: doc/BRIEF.md
# GPIO Pin Function and Output Register Block

This block is the register front end of a 54-pin general-purpose I/O port on a simple 32-bit register bus. Every pin has a 3-bit function code. The code makes the pin an input or an output, or hands the pin to one of six alternate peripherals. The block decodes each code into a per-pin output enable and a one-hot alternate-function select, and sends both to an external pad mux.

Software never rewrites the output latches as a whole word. It writes ones to a set register or to a clear register, and each 1 changes only its own pin. A read-only level register returns the pin inputs after a two-flop synchronizer. The pins are grouped in 32-bit banks, so each per-bank register kind takes two consecutive words. Read data comes out of a register one cycle after the read strobe.

Top module: `gpio_fsel_regs`

## Requirements
- R1: After a synchronous reset, every function code is 0, every output latch is 0, `pin_oe` and `alt_sel` are all zero, and every select word reads 0.
- R2: The 3-bit function code of pin p lives in the select word at byte offset 4*(p/10), in bits 3*(p%10)+2 down to 3*(p%10). A write to that word stores the code and a later read returns it.
- R3: Bits 30 and 31 of every select word read as zero and ignore writes. In the word at offset 0x14, the bits above those of pin 53 (bits 12 to 31) also read as zero and ignore writes.
- R4: `pin_oe[p]` is 1 only while pin p holds code 1. The output updates on the second rising edge after the write is presented.
- R5: `alt_sel[6p+5:6p]` is one-hot for codes 2 to 7: code 4 gives bit 0, code 5 bit 1, code 6 bit 2, code 7 bit 3, code 3 bit 4 and code 2 bit 5. Codes 0 and 1 give all zeros. It updates with the same timing as R4.
- R6: A write to the set words (offset 0x1C for pins 0 to 31, offset 0x20 for pins 32 to 53, pin p at bit p%32) sets the output latch of every pin whose bit is 1. The change shows at `pin_out` after the capturing edge. Pins whose bit is 0 keep their value.
- R7: A write to the clear words (offset 0x28 and 0x2C, same bit layout as R6) clears the output latch of every pin whose bit is 1. Pins whose bit is 0 keep their value.
- R8: Reads of the set and clear words, and reads of unmapped offsets such as 0x18, return zero.
- R9: The level words (offset 0x34 and 0x38, same bit layout as R6) return `pin_in` after two synchronizer flops. A read presented in the same cycle as an input change, or one cycle later, returns the old level. A read presented two cycles later returns the new level. Level bits above pin 53 read zero, and writes to the level words have no effect.
- R10: `bus_rdata` takes the addressed word on the rising edge where `bus_rd` is high and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 8 | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 54 | Asynchronous pin levels |
| pin_out | output | 54 | Output latch per pin |
| pin_oe | output | 54 | Output enable per pin |
| alt_sel | output | 324 | Six one-hot alternate selects per pin, pin p at bits 6p+5:6p |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high in the same cycle and that one write carries one address. Under those assumptions a set or clear write changes only the bank it addresses, and with no such write `pin_out` holds. The bench keeps inside these assumptions: each bus operation starts on a falling edge and covers exactly one cycle, and reads and writes are never overlapped. `pin_in` changes only on falling edges, so the synchronizer latency can be counted to the exact edge.

// File: rtl/gpio_fsel_pkg.sv
`timescale 1ns/1ps
package gpio_fsel_pkg;
  localparam int FSEL_W  = 3;
  localparam int NUM_ALT = 6;

  typedef enum logic [FSEL_W-1:0] {
    FS_INPUT  = 3'd0,
    FS_OUTPUT = 3'd1,
    FS_ALT_F  = 3'd2,
    FS_ALT_E  = 3'd3,
    FS_ALT_A  = 3'd4,
    FS_ALT_B  = 3'd5,
    FS_ALT_C  = 3'd6,
    FS_ALT_D  = 3'd7
  } fsel_code_e;

  // Non-monotonic mapping from function code to alternate-select bit
  function automatic logic [NUM_ALT-1:0] alt_onehot(input logic [FSEL_W-1:0] code);
    logic [NUM_ALT-1:0] r;
    case (fsel_code_e'(code))
      FS_ALT_A: r = 6'b000001;
      FS_ALT_B: r = 6'b000010;
      FS_ALT_C: r = 6'b000100;
      FS_ALT_D: r = 6'b001000;
      FS_ALT_E: r = 6'b010000;
      FS_ALT_F: r = 6'b100000;
      default:  r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/gpio_fsel_bank.sv
`timescale 1ns/1ps
module gpio_fsel_bank
  import gpio_fsel_pkg::*;
#(
  parameter int NUM_PINS      = 54,
  parameter int DATA_W        = 32,
  parameter int IDX_W         = 6,
  parameter int PINS_PER_WORD = 10,
  parameter int FSEL_BASE     = 0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [IDX_W-1:0]           rd_idx,
  output logic [DATA_W-1:0]          rd_word,
  output logic [NUM_PINS-1:0]        oe_q,
  output logic [NUM_PINS*NUM_ALT-1:0] alt_q
);
  localparam int CODE_BITS = NUM_PINS * FSEL_W;

  logic [CODE_BITS-1:0] code_q;
  logic unused_wdata;
  assign unused_wdata = ^wdata;

  // Code storage: each pin picks its slice out of its own select word
  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
    end else if (wr_en) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (wr_idx == IDX_W'(FSEL_BASE + p / PINS_PER_WORD))
          code_q[p*FSEL_W +: FSEL_W] <= wdata[FSEL_W*(p % PINS_PER_WORD) +: FSEL_W];
      end
    end
  end

  // Registered decode toward the pad mux
  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q  <= '0;
      alt_q <= '0;
    end else begin
      for (int p = 0; p < NUM_PINS; p++) begin
        oe_q[p]                   <= (code_q[p*FSEL_W +: FSEL_W] == FS_OUTPUT);
        alt_q[p*NUM_ALT +: NUM_ALT] <= alt_onehot(code_q[p*FSEL_W +: FSEL_W]);
      end
    end
  end

  // Read-back of one select word; absent slots stay zero
  always_comb begin
    rd_word = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (rd_idx == IDX_W'(FSEL_BASE + p / PINS_PER_WORD))
        rd_word[FSEL_W*(p % PINS_PER_WORD) +: FSEL_W] = code_q[p*FSEL_W +: FSEL_W];
    end
  end
endmodule

// File: rtl/gpio_out_latch.sv
`timescale 1ns/1ps
module gpio_out_latch #(
  parameter int NUM_PINS = 54,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 6,
  parameter int SET_BASE = 7,
  parameter int CLR_BASE = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [DATA_W-1:0]   wdata,
  output logic [NUM_PINS-1:0] out_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
    end else if (wr_en) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (wr_idx == IDX_W'(SET_BASE + p / DATA_W) && wdata[p % DATA_W])
          out_q[p] <= 1'b1;
        else if (wr_idx == IDX_W'(CLR_BASE + p / DATA_W) && wdata[p % DATA_W])
          out_q[p] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
  parameter int NUM_PINS = 54,
  parameter int STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] lvl
);
  logic [NUM_PINS-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= pin_in;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign lvl = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_fsel_regs.sv
`timescale 1ns/1ps
module gpio_fsel_regs
  import gpio_fsel_pkg::*;
#(
  parameter int NUM_PINS      = 54,
  parameter int DATA_W        = 32,
  parameter int ADDR_W        = 8,
  parameter int PINS_PER_WORD = 10,
  parameter int SYNC_STAGES   = 2,
  parameter int FSEL_BASE     = 0,
  parameter int SET_BASE      = 7,
  parameter int CLR_BASE      = 10,
  parameter int LEV_BASE      = 13
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  input  logic [NUM_PINS-1:0]         pin_in,
  output logic [NUM_PINS-1:0]         pin_out,
  output logic [NUM_PINS-1:0]         pin_oe,
  output logic [NUM_PINS*NUM_ALT-1:0] alt_sel
);
  localparam int IDX_W     = ADDR_W - 2;
  localparam int NUM_BANKS = (NUM_PINS + DATA_W - 1) / DATA_W;

  logic [IDX_W-1:0]            bus_idx;
  logic [1:0]                  unused_addr_lo;
  logic [DATA_W-1:0]           fsel_rd;
  logic [NUM_PINS-1:0]         lvl_sync;
  logic [NUM_BANKS*DATA_W-1:0] lvl_pad;
  logic [DATA_W-1:0]           rd_mux;
  logic [DATA_W-1:0]           rdata_q;

  assign bus_idx        = bus_addr[ADDR_W-1:2];
  assign unused_addr_lo = bus_addr[1:0];

  gpio_fsel_bank #(
    .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .IDX_W(IDX_W),
    .PINS_PER_WORD(PINS_PER_WORD), .FSEL_BASE(FSEL_BASE)
  ) u_fsel (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .wr_idx(bus_idx), .wdata(bus_wdata),
    .rd_idx(bus_idx), .rd_word(fsel_rd), .oe_q(pin_oe), .alt_q(alt_sel)
  );

  gpio_out_latch #(
    .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .IDX_W(IDX_W),
    .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
  ) u_out (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .wr_idx(bus_idx), .wdata(bus_wdata),
    .out_q(pin_out)
  );

  gpio_in_sync #(
    .NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk(clk), .rst(rst), .pin_in(pin_in), .lvl(lvl_sync)
  );

  // Read mux: select words come from the bank, levels are added here,
  // set/clear and unmapped words fall through as zero
  always_comb begin
    lvl_pad = '0;
    lvl_pad[NUM_PINS-1:0] = lvl_sync;
    rd_mux = fsel_rd;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bus_idx == IDX_W'(LEV_BASE + b))
        rd_mux = lvl_pad[b*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/gpio_fsel_chk.sv
`timescale 1ns/1ps
module gpio_fsel_chk #(
  parameter int NUM_PINS = 54,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int NUM_ALT  = 6,
  parameter int SET_BASE = 7,
  parameter int CLR_BASE = 10
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        bus_wr,
  input logic                        bus_rd,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic [DATA_W-1:0]           bus_wdata,
  input logic [DATA_W-1:0]           bus_rdata,
  input logic [NUM_PINS-1:0]         pin_out,
  input logic [NUM_PINS-1:0]         pin_oe,
  input logic [NUM_PINS*NUM_ALT-1:0] alt_sel
);
  localparam int IDX_W     = ADDR_W - 2;
  localparam int NUM_BANKS = (NUM_PINS + DATA_W - 1) / DATA_W;
  localparam int B0        = (NUM_PINS < DATA_W) ? NUM_PINS : DATA_W;

  logic [IDX_W-1:0] idx;
  logic [1:0]       unused_lo;
  logic             hit_set0, hit_clr0, hit_latch, hit_zero_rd;

  assign idx         = bus_addr[ADDR_W-1:2];
  assign unused_lo   = bus_addr[1:0];
  assign hit_set0    = bus_wr && idx == IDX_W'(SET_BASE);
  assign hit_clr0    = bus_wr && idx == IDX_W'(CLR_BASE);
  assign hit_latch   = bus_wr && ((idx >= IDX_W'(SET_BASE) && idx < IDX_W'(SET_BASE + NUM_BANKS)) ||
                                  (idx >= IDX_W'(CLR_BASE) && idx < IDX_W'(CLR_BASE + NUM_BANKS)));
  assign hit_zero_rd = bus_rd && ((idx >= IDX_W'(SET_BASE) && idx < IDX_W'(SET_BASE + NUM_BANKS)) ||
                                  (idx >= IDX_W'(CLR_BASE) && idx < IDX_W'(CLR_BASE + NUM_BANKS)));

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (pin_out == '0 && pin_oe == '0 && bus_rdata == '0));

  // R6
  set_bits_chk: assert property (@(posedge clk) disable iff (rst)
    hit_set0 |=> ((pin_out[B0-1:0] & $past(bus_wdata[B0-1:0])) == $past(bus_wdata[B0-1:0])));

  // R7
  clr_bits_chk: assert property (@(posedge clk) disable iff (rst)
    hit_clr0 |=> ((pin_out[B0-1:0] & $past(bus_wdata[B0-1:0])) == '0));

  // R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !hit_latch |=> $stable(pin_out));

  // R8
  set_clr_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    hit_zero_rd |=> (bus_rdata == '0));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    // R4
    oe_alt_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({pin_oe[p], alt_sel[p*NUM_ALT +: NUM_ALT]}));
  end
endmodule

bind gpio_fsel_regs gpio_fsel_chk #(
  .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .NUM_ALT(6), .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
) u_chk (.*);

// File: tb/tb_gpio_fsel_regs.sv
`timescale 1ns/1ps
module tb_gpio_fsel_regs;
  localparam int NP = 54;
  localparam int NA = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [7:0]        bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NP-1:0]     pin_in = '0;
  logic [NP-1:0]     pin_out;
  logic [NP-1:0]     pin_oe;
  logic [NP*NA-1:0]  alt_sel;

  int checks = 0;
  int errors = 0;
  int fs_model [NP];
  logic [NP-1:0] out_model = '0;

  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_issued = 1'b0;

  always #4 clk = ~clk;

  gpio_fsel_regs dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .alt_sel(alt_sel)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver tasks: start and end on a falling edge
  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, logic [31:0] exp, string tag);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // Monitor: compares each read result one cycle after the strobe
  always @(posedge clk) rd_issued <= bus_rd;
  always @(negedge clk) begin
    if (rd_issued) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 unexpected read data actual=%h expected=none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), 64'(bus_rdata), 64'(exp_q.pop_front()));
      end
    end
  end

  function automatic logic [31:0] fsel_word(int w);
    logic [31:0] r = '0;
    for (int p = 0; p < NP; p++)
      if (p / 10 == w) r[3*(p%10) +: 3] = 3'(fs_model[p]);
    return r;
  endfunction

  function automatic logic [5:0] exp_alt(int code);
    case (code)
      4: return 6'b000001;
      5: return 6'b000010;
      6: return 6'b000100;
      7: return 6'b001000;
      3: return 6'b010000;
      2: return 6'b100000;
      default: return 6'b000000;
    endcase
  endfunction

  task automatic check_pins(string tag);
    logic [NP-1:0] oe_exp = '0;
    logic [NP*NA-1:0] alt_exp = '0;
    for (int p = 0; p < NP; p++) begin
      oe_exp[p] = (fs_model[p] == 1);
      alt_exp[p*NA +: NA] = exp_alt(fs_model[p]);
    end
    check({tag, " R4 oe"}, 64'(pin_oe), 64'(oe_exp));
    for (int k = 0; k < NA; k++) begin
      logic [NP-1:0] a_act, a_exp;
      for (int p = 0; p < NP; p++) begin
        a_act[p] = alt_sel[p*NA + k];
        a_exp[p] = alt_exp[p*NA + k];
      end
      check($sformatf("%s R5 alt bit %0d", tag, k), 64'(a_act), 64'(a_exp));
    end
  endtask

  task automatic write_fsel(int w, logic [31:0] d);
    bus_write(8'(4*w), d);
    for (int p = 0; p < NP; p++)
      if (p / 10 == w) fs_model[p] = int'(d[3*(p%10) +: 3]);
  endtask

  task automatic latch_write(bit is_set, int bank, logic [31:0] d);
    bus_write(8'((is_set ? 8'h1C : 8'h28) + 4*bank), d);
    for (int b = 0; b < 32; b++) begin
      int p = bank*32 + b;
      if (p < NP && d[b]) out_model[p] = is_set;
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int p = 0; p < NP; p++) fs_model[p] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 pin_out", 64'(pin_out), 64'(0));
    check_pins("R1");
    for (int w = 0; w < 6; w++) bus_read(8'(4*w), 32'h0, "R1 select word");

    // R2 R3 R4 R5: code patterns, including all-ones words
    write_fsel(0, 32'hFAC6_8E88 | 32'hC000_0000);
    bus_read(8'h00, fsel_word(0), "R2 word0 readback / R3 top bits");
    @(negedge clk);
    check_pins("word0");
    write_fsel(5, 32'hFFFF_FFFF);
    bus_read(8'h14, 32'h0000_0FFF, "R3 word5 beyond pin 53");
    for (int w = 1; w < 5; w++) write_fsel(w, 32'h1234_5679 * (w + 3));
    for (int w = 1; w < 5; w++) bus_read(8'(4*w), fsel_word(w), $sformatf("R2 word%0d readback", w));
    check_pins("all words");
    write_fsel(1, 32'h0924_9249);
    bus_read(8'h04, 32'h0924_9249, "R2 all-output word1");
    @(negedge clk);
    check_pins("R4 outputs word1");

    // R6 R7 R8: set and clear
    latch_write(1, 0, 32'hA5A5_0001);
    check("R6 set bank0", 64'(pin_out), 64'(out_model));
    latch_write(1, 1, 32'hFFFF_FFFF);
    check("R6 set bank1", 64'(pin_out), 64'(out_model));
    latch_write(1, 0, 32'h0);
    check("R6 zero write no effect", 64'(pin_out), 64'(out_model));
    latch_write(0, 0, 32'h0000_FFFF);
    check("R7 clear bank0", 64'(pin_out), 64'(out_model));
    latch_write(0, 1, 32'h0020_0001);
    check("R7 clear pin 53 and 32", 64'(pin_out), 64'(out_model));
    latch_write(0, 1, 32'h0);
    check("R7 zero write no effect", 64'(pin_out), 64'(out_model));
    bus_read(8'h1C, 32'h0, "R8 set0 reads zero");
    bus_read(8'h20, 32'h0, "R8 set1 reads zero");
    bus_read(8'h28, 32'h0, "R8 clr0 reads zero");
    bus_read(8'h2C, 32'h0, "R8 clr1 reads zero");
    bus_read(8'h18, 32'h0, "R8 unmapped reads zero");
    bus_read(8'h00, fsel_word(0), "R10 select read unaffected by latch writes");

    // R9 level path and synchronizer depth
    pin_in = 54'h2A_5A5A_C3C3_0FF1;
    repeat (3) @(negedge clk);
    bus_read(8'h34, 32'hC3C3_0FF1, "R9 level bank0");
    bus_read(8'h38, 32'h002A_5A5A, "R9 level bank1 upper zero");
    bus_write(8'h34, 32'h0);
    bus_write(8'h38, 32'hFFFF_FFFF);
    bus_read(8'h34, 32'hC3C3_0FF1, "R9 level write ignored");
    check("R9 level write leaves latch", 64'(pin_out), 64'(out_model));
    pin_in = 54'h15_0000_1234_5678;
    bus_read(8'h34, 32'hC3C3_0FF1, "R9 same-cycle read old");
    bus_read(8'h34, 32'hC3C3_0FF1, "R9 one-cycle read old");
    bus_read(8'h34, 32'h1234_5678, "R9 two-cycle read new");
    bus_read(8'h38, 32'h0015_0000, "R9 bank1 new");

    // R10 rdata holds without a read strobe
    repeat (3) @(negedge clk);
    check("R10 rdata hold", 64'(bus_rdata), 64'(32'h0015_0000));

    // R1 reset again clears state
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int p = 0; p < NP; p++) fs_model[p] = 0;
    out_model = '0;
    @(negedge clk);
    check("R1 latch after reset", 64'(pin_out), 64'(0));
    check_pins("R1 after reset");
    bus_read(8'h00, 32'h0, "R1 word0 after reset");
    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R10 missing read results actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule